// File: doc/BRIEF.md
# Instruction Cycle Control Sequencer

This block is the control sequencer of a small accumulator machine. It runs each instruction through four kinds of subcycle. A fetch subcycle reads the instruction word. An indirect subcycle runs only when the word asks for it and reads the operand's effective address from memory. An execute subcycle carries out the instruction. An interrupt subcycle runs only when an interrupt is being taken. Every step is a register transfer between the program counter (PC), the memory address register (MAR), the memory buffer register (MBR), the instruction register (IR) and an accumulator (ACC).

The block talks to one single-port synchronous memory. MAR drives the memory address pins and MBR drives the write data pins. Read data is valid one cycle after the read strobe. Interrupt entry has no hidden vector jump. The sequencer saves the return address by copying PC into MBR and the stack-pointer input into MAR, writing MBR to memory, and then loading PC with a fixed handler address.

Instruction word (16 bits): bits [15:12] opcode, bit [11] indirect flag, bits [10:0] address field. Subcycle code on `phase_o`: 0 fetch, 1 indirect, 2 execute, 3 interrupt.

Top module: `icyc_sequencer`

## Requirements
- R1: A synchronous active-high reset clears PC, MAR (`mem_addr_o`), MBR (`mem_wdata_o`), IR, ACC and the interrupt-enable flag. After reset the phase is fetch (0) and neither memory strobe is active.
- R2: Each instruction starts with exactly one fetch read at the address held in PC. PC advances by one on the edge that ends that read cycle, and IR then holds the word that was read.
- R3: When bit 11 of the fetched word is 1, an indirect subcycle (phase 1) reads memory at the address field (bits [10:0]). Bits [10:0] of the word read become the effective address.
- R4: When bit 11 is 0, no indirect subcycle runs and the address field itself is the effective address.
- R5: Opcode 1 (load) reads memory at the effective address and places the word in ACC.
- R6: Opcode 2 (store) issues exactly one write of ACC to the effective address.
- R7: Opcode 3 (add) reads the word at the effective address and adds it to ACC modulo 2^16.
- R8: Opcode 4 (jump) loads PC with the effective address.
- R9: Opcode 5 sets the interrupt-enable flag and opcode 6 clears it. Opcodes 0 and 7 to 15 leave ACC and the flag unchanged and make no operand access.
- R10: If `irq_i` is high and the flag is set when an execute subcycle ends, an interrupt subcycle (phase 3) follows. It writes the zero-extended PC (the address of the next instruction) to address `sp_i`, loads PC with the handler address and clears the flag.
- R11: When the flag is clear, `irq_i` has no effect: no write happens and the next fetch comes from the sequential or jump address.
- R12: The read and write strobes are never active in the same cycle. A write happens only in the execute or interrupt phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | Interrupt request, level sensitive |
| sp_i | input | ADDR_W (11) | Stack-pointer location that receives the return address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W (11) | Memory address, driven by MAR |
| mem_wdata_o | output | DATA_W (16) | Memory write data, driven by MBR |
| mem_rdata_i | input | DATA_W (16) | Memory read data, valid one cycle after the read strobe |
| pc_o | output | ADDR_W (11) | Program counter |
| ir_o | output | DATA_W (16) | Instruction register |
| acc_o | output | DATA_W (16) | Accumulator |
| ie_o | output | 1 | Interrupt-enable flag |
| phase_o | output | 2 | Current subcycle: 0 fetch, 1 indirect, 2 execute, 3 interrupt |

## Verification
The properties rely on three things about the environment:
- The memory returns read data exactly one cycle after a read strobe.
- Reset is held for at least two clock edges, so the previous-cycle values the checker looks back at are defined.
- `irq_i` and `sp_i` stay steady from the end of execute until the save write has been issued.

The bench meets all three. Its memory model has a registered read port. It holds reset for two edges. It changes the request and the stack-pointer value only in the first fetch cycle of an instruction. It compares every instruction boundary against an instruction-level model that reads a mirrored copy of memory.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  // Sequencer steps; each step takes one clock cycle.
  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_F3,   // fetch: MAR<-PC, read+PC++, MBR<-data, IR<-MBR
    S_I0, S_I1, S_I2,         // indirect: MAR<-addr field, read, MBR<-data
    S_E0, S_E1, S_E2, S_E3,   // execute: MAR<-EA, access, capture, ACC update
    S_N0, S_N1, S_N2          // interrupt: MBR<-PC/MAR<-SP, write, PC<-handler
  } step_t;

  localparam logic [1:0] PH_FETCH = 2'd0;
  localparam logic [1:0] PH_IND   = 2'd1;
  localparam logic [1:0] PH_EXEC  = 2'd2;
  localparam logic [1:0] PH_INT   = 2'd3;

  localparam int OPC_LOAD  = 1;
  localparam int OPC_STORE = 2;
  localparam int OPC_ADD   = 3;
  localparam int OPC_JUMP  = 4;
  localparam int OPC_IEON  = 5;
  localparam int OPC_IEOFF = 6;

  function automatic logic [1:0] phase_of(step_t s);
    case (s)
      S_I0, S_I1, S_I2:       return PH_IND;
      S_E0, S_E1, S_E2, S_E3: return PH_EXEC;
      S_N0, S_N1, S_N2:       return PH_INT;
      default:                return PH_FETCH;
    endcase
  endfunction

endpackage

// File: rtl/icyc_decode.sv
module icyc_decode #(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] opcode_i,
  output logic            is_load_o,
  output logic            is_store_o,
  output logic            is_add_o,
  output logic            is_jump_o,
  output logic            is_ieon_o,
  output logic            is_ieoff_o,
  output logic            reads_operand_o
);
  import icyc_pkg::*;

  always_comb begin
    is_load_o       = (opcode_i == OP_W'(OPC_LOAD));
    is_store_o      = (opcode_i == OP_W'(OPC_STORE));
    is_add_o        = (opcode_i == OP_W'(OPC_ADD));
    is_jump_o       = (opcode_i == OP_W'(OPC_JUMP));
    is_ieon_o       = (opcode_i == OP_W'(OPC_IEON));
    is_ieoff_o      = (opcode_i == OP_W'(OPC_IEOFF));
    reads_operand_o = is_load_o | is_add_o;
  end

endmodule

// File: rtl/icyc_ctrl.sv
module icyc_ctrl (
  input  logic              clk,
  input  logic              rst,
  input  logic              ind_flag_i,
  input  logic              irq_i,
  input  logic              ie_i,
  input  logic              is_store_i,
  input  logic              reads_operand_i,
  output icyc_pkg::step_t   step_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o
);
  import icyc_pkg::*;

  step_t step_q, step_d;

  always_comb begin
    step_d = S_F0;
    case (step_q)
      S_F0: step_d = S_F1;
      S_F1: step_d = S_F2;
      S_F2: step_d = S_F3;
      S_F3: step_d = ind_flag_i ? S_I0 : S_E0;
      S_I0: step_d = S_I1;
      S_I1: step_d = S_I2;
      S_I2: step_d = S_E0;
      S_E0: step_d = S_E1;
      S_E1: step_d = S_E2;
      S_E2: step_d = S_E3;
      S_E3: step_d = (irq_i && ie_i) ? S_N0 : S_F0;
      S_N0: step_d = S_N1;
      S_N1: step_d = S_N2;
      default: step_d = S_F0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= S_F0;
    else     step_q <= step_d;
  end

  always_comb begin
    mem_rd_o = (step_q == S_F1) || (step_q == S_I1) ||
               ((step_q == S_E1) && reads_operand_i);
    mem_wr_o = ((step_q == S_E1) && is_store_i) || (step_q == S_N1);
  end

  assign step_o = step_q;

endmodule

// File: rtl/icyc_datapath.sv
module icyc_datapath #(
  parameter int          DATA_W       = 16,
  parameter int          ADDR_W       = 11,
  parameter int unsigned HANDLER_ADDR = 'h700
) (
  input  logic              clk,
  input  logic              rst,
  input  icyc_pkg::step_t   step_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              is_load_i,
  input  logic              is_store_i,
  input  logic              is_add_i,
  input  logic              is_jump_i,
  input  logic              is_ieon_i,
  input  logic              is_ieoff_i,
  input  logic              reads_operand_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              ie_o
);
  import icyc_pkg::*;

  localparam int PAD_W = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] HANDLER = ADDR_W'(HANDLER_ADDR);

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mbr_q, ir_q, acc_q;
  logic              ie_q;
  logic [DATA_W-1:0] pc_wide;

  assign pc_wide = {{PAD_W{1'b0}}, pc_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      ie_q  <= 1'b0;
    end else begin
      case (step_i)
        S_F0: mar_q <= pc_q;
        S_F1: pc_q  <= pc_q + ADDR_W'(1);
        S_F2: mbr_q <= mem_rdata_i;
        S_F3: ir_q  <= mbr_q;
        S_I0: mar_q <= mbr_q[ADDR_W-1:0];
        S_I2: mbr_q <= mem_rdata_i;
        S_E0: begin
          mar_q <= mbr_q[ADDR_W-1:0];
          if (is_store_i) mbr_q <= acc_q;
        end
        S_E1: begin
          if (is_jump_i) pc_q <= mar_q;
          if (is_ieon_i)       ie_q <= 1'b1;
          else if (is_ieoff_i) ie_q <= 1'b0;
        end
        S_E2: if (reads_operand_i) mbr_q <= mem_rdata_i;
        S_E3: begin
          if (is_load_i)     acc_q <= mbr_q;
          else if (is_add_i) acc_q <= acc_q + mbr_q;
        end
        S_N0: begin
          mbr_q <= pc_wide;
          mar_q <= sp_i;
        end
        S_N1: ie_q <= 1'b0;
        S_N2: pc_q <= HANDLER;
        default: ;
      endcase
    end
  end

  assign pc_o  = pc_q;
  assign mar_o = mar_q;
  assign mbr_o = mbr_q;
  assign ir_o  = ir_q;
  assign acc_o = acc_q;
  assign ie_o  = ie_q;

endmodule

// File: rtl/icyc_sequencer.sv
module icyc_sequencer #(
  parameter int          OP_W         = 4,
  parameter int          ADDR_W       = 11,
  parameter int unsigned HANDLER_ADDR = 'h700,
  localparam int         DATA_W       = OP_W + 1 + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              ie_o,
  output logic [1:0]        phase_o
);
  import icyc_pkg::*;

  localparam int IND_BIT = ADDR_W;

  step_t             step;
  logic              is_load, is_store, is_add, is_jump, is_ieon, is_ieoff, reads_operand;
  logic [DATA_W-1:0] mbr, ir;
  logic              ie;

  icyc_decode #(.OP_W(OP_W)) u_decode (
    .opcode_i        (ir[DATA_W-1 -: OP_W]),
    .is_load_o       (is_load),
    .is_store_o      (is_store),
    .is_add_o        (is_add),
    .is_jump_o       (is_jump),
    .is_ieon_o       (is_ieon),
    .is_ieoff_o      (is_ieoff),
    .reads_operand_o (reads_operand)
  );

  icyc_ctrl u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .ind_flag_i      (mbr[IND_BIT]),
    .irq_i           (irq_i),
    .ie_i            (ie),
    .is_store_i      (is_store),
    .reads_operand_i (reads_operand),
    .step_o          (step),
    .mem_rd_o        (mem_rd_o),
    .mem_wr_o        (mem_wr_o)
  );

  icyc_datapath #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_dp (
    .clk             (clk),
    .rst             (rst),
    .step_i          (step),
    .sp_i            (sp_i),
    .mem_rdata_i     (mem_rdata_i),
    .is_load_i       (is_load),
    .is_store_i      (is_store),
    .is_add_i        (is_add),
    .is_jump_i       (is_jump),
    .is_ieon_i       (is_ieon),
    .is_ieoff_i      (is_ieoff),
    .reads_operand_i (reads_operand),
    .pc_o            (pc_o),
    .mar_o           (mem_addr_o),
    .mbr_o           (mbr),
    .ir_o            (ir),
    .acc_o           (acc_o),
    .ie_o            (ie)
  );

  assign mem_wdata_o = mbr;
  assign ir_o        = ir;
  assign ie_o        = ie;
  assign phase_o     = phase_of(step);

endmodule

// File: rtl/icyc_sequencer_chk.sv
module icyc_sequencer_chk #(
  parameter int          ADDR_W       = 11,
  parameter int          DATA_W       = 16,
  parameter int unsigned HANDLER_ADDR = 'h700
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_i,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              ie_o,
  input logic [1:0]        phase_o
);
  import icyc_pkg::*;

  localparam logic [ADDR_W-1:0] HANDLER = ADDR_W'(HANDLER_ADDR);

  p_rw_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));

  p_write_phase_r12: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> (phase_o == PH_EXEC || phase_o == PH_INT));

  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && phase_o == PH_FETCH) |-> (mem_addr_o == pc_o));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && phase_o == PH_FETCH) |=> (pc_o == $past(pc_o) + ADDR_W'(1)));

  p_save_data_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_o && phase_o == PH_INT) |-> (mem_wdata_o[ADDR_W-1:0] == pc_o &&
                                         mem_wdata_o[DATA_W-1:ADDR_W] == '0));

  p_ie_cleared_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_o && phase_o == PH_INT) |=> !ie_o);

  p_handler_load_r10: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_FETCH && $past(phase_o) == PH_INT) |-> (pc_o == HANDLER));

  p_entry_gated_r11: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_INT && $past(phase_o) == PH_EXEC) |-> ($past(ie_o) && $past(irq_i)));

endmodule

bind icyc_sequencer icyc_sequencer_chk #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .HANDLER_ADDR (HANDLER_ADDR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq_i       (irq_i),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .pc_o        (pc_o),
  .ie_o        (ie_o),
  .phase_o     (phase_o)
);

// File: tb/icyc_sequencer_test.sv
module icyc_sequencer_test;
  import icyc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int OP_W       = 4;
  localparam int ADDR_W     = 11;
  localparam int DATA_W     = 16;
  localparam int HANDLER    = 'h700;
  localparam int DEPTH      = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              irq = 1'b0;
  logic [ADDR_W-1:0] sp  = '0;
  logic              mem_rd, mem_wr, ie;
  logic [ADDR_W-1:0] mem_addr, pc;
  logic [DATA_W-1:0] mem_wdata, ir, acc;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic [1:0]        phase;

  logic              ld_en = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [DATA_W-1:0] ld_data = '0;
  logic [DATA_W-1:0] ram [DEPTH];

  logic [DATA_W-1:0] mm [DEPTH];
  logic [ADDR_W-1:0] m_pc;
  logic [DATA_W-1:0] m_acc;
  logic              m_ie;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icyc_sequencer #(.OP_W(OP_W), .ADDR_W(ADDR_W), .HANDLER_ADDR(HANDLER)) uut (
    .clk(clk), .rst(rst), .irq_i(irq), .sp_i(sp),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .pc_o(pc), .ir_o(ir), .acc_o(acc), .ie_o(ie), .phase_o(phase)
  );

  always @(posedge clk) begin
    if (ld_en)       ram[ld_addr] <= ld_data;
    else if (mem_wr) ram[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr];
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    mm[a] = d;
  endtask

  task automatic load_end();
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_pc = '0; m_acc = '0; m_ie = 1'b0;
  endtask

  task automatic check_reset_state();
    check("R1", "pc",    32'(pc), 0);
    check("R1", "mar",   32'(mem_addr), 0);
    check("R1", "mbr",   32'(mem_wdata), 0);
    check("R1", "ir",    32'(ir), 0);
    check("R1", "acc",   32'(acc), 0);
    check("R1", "ie",    32'(ie), 0);
    check("R1", "phase", 32'(phase), 32'(PH_FETCH));
    check("R1", "strobes", {30'd0, mem_rd, mem_wr}, 0);
  endtask

  function automatic logic [DATA_W-1:0] enc(int op, bit ind, int a);
    return {OP_W'(op), ind, ADDR_W'(a)};
  endfunction

  task automatic run_instr(bit irq_v, logic [ADDR_W-1:0] sp_v);
    logic [DATA_W-1:0] word;
    logic [ADDR_W-1:0] fetch_a, ea, a, first_a;
    logic [OP_W-1:0]   op;
    bit                ind, took, overlap, timed_out;
    int                exp_rd, exp_wr, n_rd, n_wr, cyc;
    logic [1:0]        prev;
    string             tag;
    irq = irq_v; sp = sp_v;
    word = mm[m_pc]; fetch_a = m_pc;
    op = word[DATA_W-1 -: OP_W]; ind = word[ADDR_W]; a = word[ADDR_W-1:0];
    m_pc = m_pc + ADDR_W'(1);
    ea = ind ? mm[a][ADDR_W-1:0] : a;
    exp_rd = ind ? 2 : 1; exp_wr = 0;
    case (int'(op))
      OPC_LOAD:  begin m_acc = mm[ea]; exp_rd++; end
      OPC_STORE: begin mm[ea] = m_acc; exp_wr++; end
      OPC_ADD:   begin m_acc = m_acc + mm[ea]; exp_rd++; end
      OPC_JUMP:  m_pc = ea;
      OPC_IEON:  m_ie = 1'b1;
      OPC_IEOFF: m_ie = 1'b0;
      default: ;
    endcase
    took = irq_v && m_ie;
    if (took) begin
      mm[sp_v] = {{(DATA_W-ADDR_W){1'b0}}, m_pc};
      m_pc = ADDR_W'(HANDLER); m_ie = 1'b0; exp_wr++;
    end
    n_rd = 0; n_wr = 0; first_a = '0; overlap = 0; timed_out = 0; cyc = 0; prev = PH_FETCH;
    forever begin
      @(negedge clk);
      cyc++;
      if (mem_rd) begin
        if (n_rd == 0) first_a = mem_addr;
        n_rd++;
      end
      if (mem_wr) n_wr++;
      if (mem_rd && mem_wr) overlap = 1;
      if (phase == PH_FETCH && prev != PH_FETCH) break;
      prev = phase;
      if (cyc > 40) begin timed_out = 1; break; end
    end
    check("R2", "instruction completes", 32'(timed_out), 0);
    check("R2", "fetch address", 32'(first_a), 32'(fetch_a));
    tag = ind ? "R3" : "R4";
    check(tag, "read count", 32'(n_rd), 32'(exp_rd));
    tag = took ? "R10" : (int'(op) == OPC_STORE ? "R6" : (irq_v ? "R11" : "R12"));
    check(tag, "write count", 32'(n_wr), 32'(exp_wr));
    check("R12", "strobe overlap", 32'(overlap), 0);
    check("R2", "ir", 32'(ir), 32'(word));
    tag = took ? "R10" : (int'(op) == OPC_JUMP ? "R8" : (irq_v ? "R11" : "R2"));
    check(tag, "pc", 32'(pc), 32'(m_pc));
    tag = int'(op) == OPC_LOAD ? "R5" : (int'(op) == OPC_ADD ? "R7" : "R9");
    check(tag, "acc", 32'(acc), 32'(m_acc));
    tag = took ? "R10" : "R9";
    check(tag, "ie", 32'(ie), 32'(m_ie));
  endtask

  task automatic compare_memory(string tag);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++)
      if (ram[i] !== mm[i]) bad++;
    check(tag, "memory image mismatches", 32'(bad), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    // directed program
    for (int i = 0; i < DEPTH; i++) put(ADDR_W'(i), '0);
    put(11'h000, enc(OPC_LOAD, 0, 'h100));
    put(11'h001, enc(OPC_ADD, 1, 'h101));
    put(11'h002, enc(OPC_STORE, 0, 'h103));
    put(11'h003, enc(OPC_IEON, 0, 0));
    put(11'h004, enc(0, 0, 0));
    put(11'h100, 16'h1234);
    put(11'h101, 16'h0102);
    put(11'h102, 16'hFFFF);
    put(11'h700, enc(OPC_IEOFF, 0, 0));
    put(11'h701, enc(0, 0, 0));
    put(11'h702, enc(OPC_JUMP, 1, 'h110));
    put(11'h110, 16'h0020);
    put(11'h020, enc(OPC_STORE, 1, 'h111));
    put(11'h111, 16'h0112);
    put(11'h021, enc(9, 1, 'h555));
    load_end();
    do_reset();
    check_reset_state();                 // R1
    run_instr(0, '0);                    // R5 load
    run_instr(0, '0);                    // R3, R7 add with wrap
    check("R7", "acc after wrapping add", 32'(acc), 32'h1233);
    run_instr(0, '0);                    // R6 store
    run_instr(0, '0);                    // R9 enable
    run_instr(1, 11'h7FF);               // R10 interrupt entry
    check("R10", "pc at handler", 32'(pc), 32'(HANDLER));
    check("R10", "saved return address", 32'(ram[11'h7FF]), 32'h0005);
    run_instr(1, 11'h7F0);               // R11 disable under request
    run_instr(1, 11'h7F0);               // R11 request ignored
    check("R11", "no save write", 32'(ram[11'h7F0]), 0);
    run_instr(0, '0);                    // R8, R3 indirect jump
    check("R8", "jump target", 32'(pc), 32'h020);
    run_instr(0, '0);                    // R6 indirect store
    check("R6", "indirect store", 32'(ram[11'h112]), 32'h1233);
    check("R6", "direct store", 32'(ram[11'h103]), 32'h1233);
    run_instr(0, '0);                    // R9 unused opcode, R3 indirect read only
    compare_memory("R6");
    do_reset();
    check_reset_state();                 // R1 after a busy run

    // random program
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      int op = $urandom_range(0, 7);
      bit ind = ($urandom_range(0, 3) == 0);
      put(ADDR_W'(i), enc(op, ind, $urandom_range(0, DEPTH-1)));
    end
    load_end();
    do_reset();
    check_reset_state();
    for (int n = 0; n < 400; n++)
      run_instr($urandom_range(0, 3) == 0, ADDR_W'($urandom_range(0, DEPTH-1)));
    compare_memory("R10");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R2 watchdog: actual expired expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule